// File: doc/BRIEF.md
# Processor Mode Control Register File

This block keeps the privileged control state of one processor thread. That state covers the two paging control words (`ctl0`, `ctl4`), the page-table root (`ctl3`), the extended feature word, the code and stack segment attribute bytes, the flags word that holds the virtual-8086 bit, the two debug registers for status and control, and a time-stamp offset. Software-side logic writes one register per cycle through an index/data port, and an asynchronous read port returns any register by index.

Some writes have side effects. Toggling paging while long mode is enabled changes the long-mode-active bit. A fixed bit of `ctl0` always reads as one. Two debug indices are aliases of two others, and only some status bits take the written value. Writes to the paging controls request TLB flushes as single-cycle pulses. The block keeps a packed, decoded mode word that tells the decoder the operating mode and submode, the privilege level, and the default and alternate operand and address sizes together with the stack size. That word is recomputed on writes to `ctl0` or to either attribute byte, and on an explicit refresh write. Breakpoint matching, the page walker and the TLB are not part of this block.

Top module: `mode_ctl_regfile`

## Requirements
- R1: After reset every register reads zero, with two exceptions: debug status reads 0xFFFF0FF0 and debug control reads 0x400. Both flush outputs are low. The mode word is the one computed from all-zero registers: Real submode, operand codes 1/2, address codes 1/2, stack code 1.
- R2: Mode word bit 0 (long) equals EFER bit 10 (long-mode-active). Bits [3:1] hold the submode. When long is 1, the submode is 4 (64-bit) if code attribute bit 3 is set and 3 (compatibility) otherwise. When long is 0, the submode is 2 (virtual-8086) if ctl0 bit 0 is 1 and flags bit 17 is 1. It is 1 (protected) if ctl0 bit 0 is 1 and flags bit 17 is 0, and 0 (real) if ctl0 bit 0 is 0.
- R3: Operand size codes sit at bits [9:8] (default) and [11:10] (alternate). They are 2/1 in the 64-bit submode or when code attribute bit 2 (default size) is set, and 1/2 otherwise.
- R4: Address size codes sit at bits [13:12] (default) and [15:14] (alternate). They are 3/2 in the 64-bit submode, 2/1 when code attribute bit 2 is set, and 1/2 otherwise. The stack code at bits [17:16] is 3 in the 64-bit submode, 2 when stack attribute bit 2 is set, and 1 otherwise.
- R5: Mode word bits [5:4] hold the privilege level, taken from code attribute bits [1:0]. Bit 6 equals ctl0 bit 31 (paging) and bit 7 equals ctl0 bit 0 (protection).
- R6: A write to ctl0 (index 0), the code attribute (index 4), the stack attribute (index 5) or the refresh index 12 updates the mode word in the cycle after the write. For index 12 the written data is discarded and the word is rebuilt from the current registers. Writes to EFER (index 3) or flags (index 6) leave the mode word unchanged until the next such update.
- R7: ctl0 bit 4 always reads as 1 after a ctl0 write. When a ctl0 write toggles bit 31 while EFER bit 8 (long-mode-enable) is 1, EFER bit 10 takes the new value of bit 31.
- R8: `flushAll` is high for exactly the one cycle after a ctl0 write that toggles bit 31. It is also high for the one cycle after a ctl4 (index 2) write that toggles bit 4, 5 or 7. Any other ctl4 write leaves it low.
- R9: `flushNonGlobal` is high for exactly the one cycle after any write to ctl3 (index 1).
- R10: A write to index 7 goes to debug status (index 9), and a write to index 8 goes to debug control (index 10). A debug status write changes only bits 0–3 and 13–15; every other bit keeps its value.
- R11: Reading the time-stamp index 11 returns the stored offset plus a free-running cycle count. A write stores the data minus the current count, so a read k cycles after the write returns the data plus k.
- R12: `rdData` shows the register selected by `rdIdx` in the same cycle. Index 12 returns the mode word, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrIdx | input | 4 | Write register index |
| wrData | input | 64 | Write data |
| rdIdx | input | 4 | Read register index |
| rdData | output | 64 | Read data for rdIdx |
| modeWord | output | 18 | Decoded mode word |
| flushAll | output | 1 | Full TLB flush request pulse |
| flushNonGlobal | output | 1 | Non-global TLB flush request pulse |

## Verification
The hardest state to reach from the ports is the 64-bit submode. Long-mode-active cannot be written into effect: it appears only when a ctl0 write turns paging on while long-mode-enable is already set, and even then the mode word also depends on the code attribute's long bit. The stimulus table follows that order. It first enables the extended feature, which must leave the mode word stale. It then loads a long code segment, which still decodes as protected mode, and only then toggles paging. After that it leaves through compatibility mode and turns paging off again. Along the way a flags write followed by a refresh write shows the stale-until-refresh behaviour.

// File: rtl/modectl_pkg.sv
package modectl_pkg;

  localparam int IdxW  = 4;
  localparam int AttrW = 8;

  // register indices
  localparam logic [IdxW-1:0] IDX_CTL0  = 4'd0;
  localparam logic [IdxW-1:0] IDX_CTL3  = 4'd1;
  localparam logic [IdxW-1:0] IDX_CTL4  = 4'd2;
  localparam logic [IdxW-1:0] IDX_EFER  = 4'd3;
  localparam logic [IdxW-1:0] IDX_CSATT = 4'd4;
  localparam logic [IdxW-1:0] IDX_SSATT = 4'd5;
  localparam logic [IdxW-1:0] IDX_FLAGS = 4'd6;
  localparam logic [IdxW-1:0] IDX_DBGA4 = 4'd7;
  localparam logic [IdxW-1:0] IDX_DBGA5 = 4'd8;
  localparam logic [IdxW-1:0] IDX_DSTAT = 4'd9;
  localparam logic [IdxW-1:0] IDX_DCTRL = 4'd10;
  localparam logic [IdxW-1:0] IDX_TSTMP = 4'd11;
  localparam logic [IdxW-1:0] IDX_MODE  = 4'd12;

  // bit positions
  localparam int CTL0_PE   = 0;
  localparam int CTL0_ET   = 4;
  localparam int CTL0_PG   = 31;
  localparam int CTL4_PSE  = 4;
  localparam int CTL4_PAE  = 5;
  localparam int CTL4_PGE  = 7;
  localparam int EFER_LME  = 8;
  localparam int EFER_LMA  = 10;
  localparam int ATT_DEF   = 2;
  localparam int ATT_LONG  = 3;
  localparam int FLAGS_VM  = 17;

  localparam logic [31:0] DSTAT_WMASK = 32'h0000_E00F;
  localparam logic [31:0] DSTAT_RST   = 32'hFFFF_0FF0;
  localparam logic [31:0] DCTRL_RST   = 32'h0000_0400;

  typedef enum logic [2:0] {
    SUB_REAL   = 3'd0,
    SUB_PROT   = 3'd1,
    SUB_V86    = 3'd2,
    SUB_COMPAT = 3'd3,
    SUB_X64    = 3'd4
  } submode_e;

  typedef struct packed {
    logic [1:0] stack;
    logic [1:0] altAddr;
    logic [1:0] defAddr;
    logic [1:0] altOp;
    logic [1:0] defOp;
    logic       prot;
    logic       paging;
    logic [1:0] cpl;
    submode_e   sub;
    logic       longMode;
  } modeWord_t;

  localparam int ModeW = $bits(modeWord_t);

  // strobes from control to datapath
  typedef struct packed {
    logic ctl0;
    logic ctl3;
    logic ctl4;
    logic efer;
    logic csAttr;
    logic ssAttr;
    logic flags;
    logic dstat;
    logic dctrl;
    logic tstmp;
    logic recompute;
    logic setLma;
    logic lmaVal;
    logic flushAll;
    logic flushNonGlobal;
  } wrStrobe_t;

  function automatic modeWord_t calcMode(
    input logic       lma,
    input logic       csLong,
    input logic       csDef,
    input logic       ssDef,
    input logic       pe,
    input logic       pg,
    input logic       vm,
    input logic [1:0] dpl
  );
    modeWord_t m;
    logic      x64;
    x64 = lma && csLong;
    m.longMode = lma;
    if (lma)      m.sub = csLong ? SUB_X64 : SUB_COMPAT;
    else if (pe)  m.sub = vm ? SUB_V86 : SUB_PROT;
    else          m.sub = SUB_REAL;
    m.cpl    = dpl;
    m.paging = pg;
    m.prot   = pe;
    if (x64 || csDef) begin
      m.defOp = 2'd2; m.altOp = 2'd1;
    end else begin
      m.defOp = 2'd1; m.altOp = 2'd2;
    end
    if (x64) begin
      m.defAddr = 2'd3; m.altAddr = 2'd2;
    end else if (csDef) begin
      m.defAddr = 2'd2; m.altAddr = 2'd1;
    end else begin
      m.defAddr = 2'd1; m.altAddr = 2'd2;
    end
    if (x64)        m.stack = 2'd3;
    else if (ssDef) m.stack = 2'd2;
    else            m.stack = 2'd1;
    return m;
  endfunction

endpackage

// File: rtl/modectl_ctrl.sv
module modectl_ctrl
  import modectl_pkg::*;
#(
  parameter int IDX_W = IdxW
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrPg,
  input  logic [2:0]       wrPageCfg,
  input  logic             curPg,
  input  logic             curLme,
  input  logic [2:0]       curPageCfg,
  output wrStrobe_t        str
);

  logic pgToggle;
  logic cfgToggle;

  function automatic logic hit(input logic en, input logic [IDX_W-1:0] idx,
                               input logic [IdxW-1:0] want);
    return en && (idx == IDX_W'(want));
  endfunction

  always_comb begin
    pgToggle  = wrPg ^ curPg;
    cfgToggle = |(wrPageCfg ^ curPageCfg);

    str.ctl0   = hit(wrEn, wrIdx, IDX_CTL0);
    str.ctl3   = hit(wrEn, wrIdx, IDX_CTL3);
    str.ctl4   = hit(wrEn, wrIdx, IDX_CTL4);
    str.efer   = hit(wrEn, wrIdx, IDX_EFER);
    str.csAttr = hit(wrEn, wrIdx, IDX_CSATT);
    str.ssAttr = hit(wrEn, wrIdx, IDX_SSATT);
    str.flags  = hit(wrEn, wrIdx, IDX_FLAGS);
    str.dstat  = hit(wrEn, wrIdx, IDX_DSTAT) || hit(wrEn, wrIdx, IDX_DBGA4);
    str.dctrl  = hit(wrEn, wrIdx, IDX_DCTRL) || hit(wrEn, wrIdx, IDX_DBGA5);
    str.tstmp  = hit(wrEn, wrIdx, IDX_TSTMP);

    str.recompute = str.ctl0 || str.csAttr || str.ssAttr ||
                    hit(wrEn, wrIdx, IDX_MODE);

    str.setLma = str.ctl0 && pgToggle && curLme;
    str.lmaVal = wrPg;

    str.flushAll       = (str.ctl0 && pgToggle) || (str.ctl4 && cfgToggle);
    str.flushNonGlobal = str.ctl3;
  end

endmodule

// File: rtl/modectl_datapath.sv
module modectl_datapath
  import modectl_pkg::*;
#(
  parameter int IDX_W  = IdxW,
  parameter int DATA_W = 64,
  parameter int ATTR_W = AttrW
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         str,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output modeWord_t         modeQ,
  output logic              flushAllQ,
  output logic              flushNgQ,
  output logic              curPg,
  output logic              curLme,
  output logic [2:0]        curPageCfg
);

  localparam logic [DATA_W-1:0] DstatWMask = DATA_W'(DSTAT_WMASK);
  localparam logic [DATA_W-1:0] DstatRst   = DATA_W'(DSTAT_RST);
  localparam logic [DATA_W-1:0] DctrlRst   = DATA_W'(DCTRL_RST);
  localparam modeWord_t ModeRst = calcMode(1'b0, 1'b0, 1'b0, 1'b0,
                                           1'b0, 1'b0, 1'b0, 2'b00);

  logic [DATA_W-1:0] ctl0Q, ctl3Q, ctl4Q, eferQ, flagsQ;
  logic [DATA_W-1:0] dstatQ, dctrlQ, tsOffQ, cycCnt;
  logic [ATTR_W-1:0] csQ, ssQ;

  logic [DATA_W-1:0] ctl0Nxt, eferNxt, flagsNxt;
  logic [ATTR_W-1:0] csNxt, ssNxt;
  modeWord_t         modeNxt;

  always_comb begin
    ctl0Nxt = ctl0Q;
    if (str.ctl0) begin
      ctl0Nxt          = wrData;
      ctl0Nxt[CTL0_ET] = 1'b1;
    end
    eferNxt = eferQ;
    if (str.efer)        eferNxt = wrData;
    else if (str.setLma) eferNxt[EFER_LMA] = str.lmaVal;
    csNxt    = str.csAttr ? wrData[ATTR_W-1:0] : csQ;
    ssNxt    = str.ssAttr ? wrData[ATTR_W-1:0] : ssQ;
    flagsNxt = str.flags  ? wrData : flagsQ;
    modeNxt  = calcMode(eferNxt[EFER_LMA], csNxt[ATT_LONG], csNxt[ATT_DEF],
                        ssNxt[ATT_DEF], ctl0Nxt[CTL0_PE], ctl0Nxt[CTL0_PG],
                        flagsNxt[FLAGS_VM], csNxt[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl0Q     <= '0;
      ctl3Q     <= '0;
      ctl4Q     <= '0;
      eferQ     <= '0;
      flagsQ    <= '0;
      csQ       <= '0;
      ssQ       <= '0;
      dstatQ    <= DstatRst;
      dctrlQ    <= DctrlRst;
      tsOffQ    <= '0;
      cycCnt    <= '0;
      modeQ     <= ModeRst;
      flushAllQ <= 1'b0;
      flushNgQ  <= 1'b0;
    end else begin
      ctl0Q  <= ctl0Nxt;
      eferQ  <= eferNxt;
      csQ    <= csNxt;
      ssQ    <= ssNxt;
      flagsQ <= flagsNxt;
      if (str.ctl3) ctl3Q <= wrData;
      if (str.ctl4) ctl4Q <= wrData;
      if (str.dstat) dstatQ <= (dstatQ & ~DstatWMask) | (wrData & DstatWMask);
      if (str.dctrl) dctrlQ <= wrData;
      if (str.tstmp) tsOffQ <= wrData - cycCnt;
      cycCnt <= cycCnt + 1'b1;
      if (str.recompute) modeQ <= modeNxt;
      flushAllQ <= str.flushAll;
      flushNgQ  <= str.flushNonGlobal;
    end
  end

  always_comb begin
    unique case (rdIdx)
      IDX_W'(IDX_CTL0):  rdData = ctl0Q;
      IDX_W'(IDX_CTL3):  rdData = ctl3Q;
      IDX_W'(IDX_CTL4):  rdData = ctl4Q;
      IDX_W'(IDX_EFER):  rdData = eferQ;
      IDX_W'(IDX_CSATT): rdData = DATA_W'(csQ);
      IDX_W'(IDX_SSATT): rdData = DATA_W'(ssQ);
      IDX_W'(IDX_FLAGS): rdData = flagsQ;
      IDX_W'(IDX_DBGA4), IDX_W'(IDX_DSTAT): rdData = dstatQ;
      IDX_W'(IDX_DBGA5), IDX_W'(IDX_DCTRL): rdData = dctrlQ;
      IDX_W'(IDX_TSTMP): rdData = tsOffQ + cycCnt;
      IDX_W'(IDX_MODE):  rdData = DATA_W'(modeQ);
      default:           rdData = '0;
    endcase
  end

  assign curPg      = ctl0Q[CTL0_PG];
  assign curLme     = eferQ[EFER_LME];
  assign curPageCfg = {ctl4Q[CTL4_PGE], ctl4Q[CTL4_PAE], ctl4Q[CTL4_PSE]};

  // R2
  mode_long_tracks_lma_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.recompute |=> (modeQ.longMode == eferQ[EFER_LMA]));

  // R6
  mode_stale_without_recompute_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.recompute |=> $stable(modeQ));

  // R7
  fixed_et_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.ctl0 |=> ctl0Q[CTL0_ET]);

  // R8
  flush_all_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !str.flushAll |=> !flushAllQ);

  // R9
  flush_ng_follows_ctl3_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.ctl3 |=> flushNgQ);

  // R10
  dstat_locked_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.dstat |=> ((dstatQ & ~DstatWMask) == $past(dstatQ & ~DstatWMask)));

endmodule

// File: rtl/mode_ctl_regfile.sv
module mode_ctl_regfile
  import modectl_pkg::*;
#(
  parameter int IDX_W  = IdxW,
  parameter int DATA_W = 64,
  parameter int MODE_W = ModeW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic [MODE_W-1:0] modeWord,
  output logic              flushAll,
  output logic              flushNonGlobal
);

  wrStrobe_t  str;
  modeWord_t  modeQ;
  logic       curPg, curLme;
  logic [2:0] curPageCfg;
  logic [2:0] wrPageCfg;

  assign wrPageCfg = {wrData[CTL4_PGE], wrData[CTL4_PAE], wrData[CTL4_PSE]};

  modectl_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .wrPg       (wrData[CTL0_PG]),
    .wrPageCfg  (wrPageCfg),
    .curPg      (curPg),
    .curLme     (curLme),
    .curPageCfg (curPageCfg),
    .str        (str)
  );

  modectl_datapath #(.IDX_W(IDX_W), .DATA_W(DATA_W), .ATTR_W(AttrW)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .str        (str),
    .wrData     (wrData),
    .rdIdx      (rdIdx),
    .rdData     (rdData),
    .modeQ      (modeQ),
    .flushAllQ  (flushAll),
    .flushNgQ   (flushNonGlobal),
    .curPg      (curPg),
    .curLme     (curLme),
    .curPageCfg (curPageCfg)
  );

  assign modeWord = MODE_W'(modeQ);

endmodule

// File: tb/mode_ctl_regfile_test.sv
`timescale 1ns/1ps
module mode_ctl_regfile_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic [3:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic [17:0] modeWord;
  logic        flushAll, flushNonGlobal;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mode_ctl_regfile uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .modeWord(modeWord),
    .flushAll(flushAll), .flushNonGlobal(flushNonGlobal)
  );

  typedef struct packed {
    logic [3:0]  idx;
    logic [31:0] data;
    logic        l;
    logic [2:0]  sub;
    logic [1:0]  cpl;
    logic        pg, pe;
    logic [1:0]  dop, aop, dad, aad, stk;
  } vec_t;

  // columns: index, data, long, submode, cpl, paging, prot, op def/alt, addr def/alt, stack
  localparam vec_t TBL [12] = '{
    '{4'd0,  32'h0000_0001, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd1},
    '{4'd4,  32'h0000_0007, 1'b0, 3'd1, 2'd3, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd1},
    '{4'd5,  32'h0000_0004, 1'b0, 3'd1, 2'd3, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd3,  32'h0000_0100, 1'b0, 3'd1, 2'd3, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd4,  32'h0000_0008, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2},
    '{4'd0,  32'h8000_0001, 1'b1, 3'd4, 2'd0, 1'b1, 1'b1, 2'd2, 2'd1, 2'd3, 2'd2, 2'd3},
    '{4'd4,  32'h0000_0000, 1'b1, 3'd3, 2'd0, 1'b1, 1'b1, 2'd1, 2'd2, 2'd1, 2'd2, 2'd2},
    '{4'd4,  32'h0000_0004, 1'b1, 3'd3, 2'd0, 1'b1, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd0,  32'h0000_0001, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd6,  32'h0002_0000, 1'b0, 3'd1, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd12, 32'h0000_DEAD, 1'b0, 3'd2, 2'd0, 1'b0, 1'b1, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2},
    '{4'd0,  32'h0000_0000, 1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 2'd2, 2'd1, 2'd2, 2'd1, 2'd2}
  };

  function automatic logic [17:0] packMode(input vec_t v);
    return {v.stk, v.aad, v.dad, v.aop, v.dop, v.pe, v.pg, v.cpl, v.sub, v.l};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [63:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdIdx = 4'd9;  #1 chk("R1 dstat reset", rdData, 64'hFFFF_0FF0);
    rdIdx = 4'd10; #1 chk("R1 dctrl reset", rdData, 64'h400);
    rdIdx = 4'd0;  #1 chk("R1 ctl0 reset", rdData, 64'h0);
    rdIdx = 4'd3;  #1 chk("R1 efer reset", rdData, 64'h0);
    chk("R1 mode reset", {46'd0, modeWord}, {46'd0, 18'h19900});
    chk("R1 flush reset", {62'd0, flushAll, flushNonGlobal}, 64'd0);

    // R2 R3 R4 R5 R6 R7: table walk, EFER readback tracks LMA
    rdIdx = 4'd3;
    for (int i = 0; i < 12; i++) begin
      wr(TBL[i].idx, {32'd0, TBL[i].data});
      chk($sformatf("R2/R3/R4/R5/R6 row %0d mode", i), {46'd0, modeWord},
          {46'd0, packMode(TBL[i])});
      if (TBL[i].idx != 4'd3)
        chk($sformatf("R7 row %0d efer lma", i), {63'd0, rdData[10]}, {63'd0, TBL[i].l});
    end

    // R12 mode word readable at index 12
    rdIdx = 4'd12; #1 chk("R12 mode readback", rdData, {46'd0, modeWord});
    // R7 fixed bit
    rdIdx = 4'd0; #1 chk("R7 ctl0 et forced", rdData, 64'h10);

    // R9 ctl3 non-global flush, one cycle
    wr(4'd1, 64'h1234_5000);
    chk("R9 flushNonGlobal high", {63'd0, flushNonGlobal}, 64'd1);
    chk("R9 flushAll stays low", {63'd0, flushAll}, 64'd0);
    @(negedge clk);
    chk("R9 flushNonGlobal one cycle", {63'd0, flushNonGlobal}, 64'd0);
    rdIdx = 4'd1; #1 chk("R12 ctl3 readback", rdData, 64'h1234_5000);

    // R8 ctl4 config toggle
    wr(4'd2, 64'h20);
    chk("R8 ctl4 pae toggle flush", {63'd0, flushAll}, 64'd1);
    @(negedge clk);
    chk("R8 flushAll one cycle", {63'd0, flushAll}, 64'd0);
    wr(4'd2, 64'h21);
    chk("R8 ctl4 other bit no flush", {63'd0, flushAll}, 64'd0);

    // R8 R7 paging toggle with LME set
    wr(4'd0, 64'h8000_0000);
    chk("R8 paging toggle flush", {63'd0, flushAll}, 64'd1);
    rdIdx = 4'd3; #1 chk("R7 lma set by paging", rdData, 64'h500);
    wr(4'd0, 64'h8000_0000);
    chk("R8 no toggle no flush", {63'd0, flushAll}, 64'd0);

    // R10 debug aliases and mask
    wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rdIdx = 4'd9; #1 chk("R10 alias to dstat masked set", rdData, 64'hFFFF_EFFF);
    wr(4'd9, 64'h0);
    #1 chk("R10 dstat masked clear", rdData, 64'hFFFF_0FF0);
    wr(4'd8, 64'h55);
    rdIdx = 4'd10; #1 chk("R10 alias to dctrl", rdData, 64'h55);

    // R11 time stamp
    wr(4'd11, 64'd1000);
    rdIdx = 4'd11; #1 chk("R11 tstamp after write", rdData, 64'd1001);
    repeat (5) @(negedge clk);
    #1 chk("R11 tstamp advances", rdData, 64'd1006);

    finishRun();
  end

endmodule